// File: doc/BRIEF.md
# Ping-Pong LIFO Data Reverser

This block supplies the time-reversed sample stream that a symmetric FIR filter needs on its second data path. It contains two stacks of equal depth. At any moment one of them fills from the forward input while the other drains onto the reverse output. A falling edge on the transfer control exchanges the two roles. The stack that just filled then returns its samples last-in first-out, and the stack that was draining restarts empty and collects the next segment.

All data movement is gated by an active-low shift enable. The transfer control is sampled every clock, whatever the shift enable is doing, so a segment boundary can be marked during a stall. The reverse output is registered. A pop from an empty stack yields zero. A push into a full stack is dropped.

Top module: `pp_lifo_reverser`

## Requirements
- R1: After reset the reverse output is 0, both stacks are empty, and stack A is the filling stack (fill select = 0).
- R2: On a rising clock edge with shift_n low, fwd_in is pushed onto the filling stack, and the top word of the draining stack is popped into rev_out, which is visible after that edge.
- R3: After a swap, the words a stack collected come out on rev_out in exactly the reverse of their push order.
- R4: A swap happens only on a clock edge where xfer was sampled high on the previous edge and is low now. Holding xfer low, holding it high, or a rising transition causes no swap.
- R5: With shift_n high, rev_out, both stack levels and the stack contents are left unchanged (apart from a swap under R8/R10).
- R6: A pop from an empty draining stack places 0 on rev_out and leaves its level at 0.
- R7: Each stack holds at most DEPTH (default 256) words. A push at full is ignored, so after a swap the first word out is the DEPTH-th word pushed.
- R8: On a swap, the newly filling stack restarts empty, and words it had not yet delivered are discarded.
- R9: When a swap and a shift fall on the same edge, the push goes into the newly filling stack as its first word, and the pop takes the top of the newly draining stack.
- R10: A swap takes place even while shift_n is high, and later shifts use the exchanged roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd_in | input | DATA_W (12) | Forward-path sample to be pushed |
| shift_n | input | 1 | Active-low shift enable for push and pop |
| xfer | input | 1 | Transfer control; a high-to-low transition swaps the stack roles |
| rev_out | output | DATA_W (12) | Registered reverse-path sample |

## Verification
A role exchange and a push/pop pair can happen on the same edge, and this is the case most likely to go wrong. The question is whether the pushed word lands at the bottom of the restarted stack and the popped word comes from the stack that has just finished. The bench brings on this case by dropping xfer while shift_n stays low, with uneven segment lengths so that unread words must be discarded. A behavioural queue model, stepped with the same inputs, supplies the expected rev_out for every cycle.

// File: rtl/pp_lifo_pkg.sv
package pp_lifo_pkg;
    typedef enum logic {
        FILL_A = 1'b0,
        FILL_B = 1'b1
    } fill_sel_e;
endpackage

// File: rtl/pp_lifo_bank.sv
module pp_lifo_bank #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 256,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] top_word,
    output logic [CNT_W-1:0]  level
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  lvl_d, lvl_q;
    logic [CNT_W-1:0]  base;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    always_comb begin
        base    = restart ? '0 : lvl_q;
        lvl_d   = base;
        wr_en   = 1'b0;
        wr_addr = ADDR_W'(base);
        if (push && (base < CNT_W'(DEPTH))) begin
            wr_en = 1'b1;
            lvl_d = base + CNT_W'(1);
        end else if (pop && (base != '0)) begin
            lvl_d = base - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= din;
    end

    assign rd_addr  = ADDR_W'(lvl_q - CNT_W'(1));
    assign top_word = (lvl_q == '0) ? '0 : mem[rd_addr];
    assign level    = lvl_q;
endmodule

// File: rtl/pp_lifo_reverser.sv
module pp_lifo_reverser #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 256,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fwd_in,
    input  logic              shift_n,
    input  logic              xfer,
    output logic [DATA_W-1:0] rev_out
);
    import pp_lifo_pkg::*;

    typedef struct packed {
        fill_sel_e         sel;
        logic              xfer;
        logic [DATA_W-1:0] rev;
    } state_t;

    state_t st_d, st_q;

    logic              swap;
    logic              shift;
    logic              fill_idx;
    logic [DATA_W-1:0] top_w [2];
    logic [CNT_W-1:0]  lvl   [2];
    logic [1:0]        bank_restart;
    logic [1:0]        bank_push;
    logic [1:0]        bank_pop;

    always_comb begin
        st_d      = st_q;
        swap      = st_q.xfer & ~xfer;
        shift     = ~shift_n;
        st_d.xfer = xfer;
        if (swap) st_d.sel = fill_sel_e'(~st_q.sel);
        fill_idx  = st_d.sel;
        if (shift) st_d.rev = top_w[~fill_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel  <= FILL_A;
            st_q.xfer <= 1'b0;
            st_q.rev  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        assign bank_restart[g] = swap  && (fill_idx == 1'(g));
        assign bank_push[g]    = shift && (fill_idx == 1'(g));
        assign bank_pop[g]     = shift && (fill_idx != 1'(g));

        pp_lifo_bank #(
            .DATA_W(DATA_W),
            .DEPTH (DEPTH)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (bank_restart[g]),
            .push    (bank_push[g]),
            .pop     (bank_pop[g]),
            .din     (fwd_in),
            .top_word(top_w[g]),
            .level   (lvl[g])
        );
    end

    assign rev_out = st_q.rev;
endmodule

// File: rtl/pp_lifo_chk.sv
module pp_lifo_chk #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 256,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_n,
    input logic              xfer,
    input logic [DATA_W-1:0] rev_out,
    input logic              sel,
    input logic              xfer_q,
    input logic [CNT_W-1:0]  lvl_a,
    input logic [CNT_W-1:0]  lvl_b
);
    logic             fall;
    logic [CNT_W-1:0] fill_lvl;
    logic [CNT_W-1:0] drain_lvl;

    assign fall      = xfer_q & ~xfer;
    assign fill_lvl  = sel ? lvl_b : lvl_a;
    assign drain_lvl = sel ? lvl_a : lvl_b;

    // R2: a shift without swap grows the filling stack by one
    a_r2_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !shift_n && (int'(fill_lvl) < DEPTH))
        |=> (int'(fill_lvl) == int'($past(fill_lvl)) + 1));

    // R4: the fill select flips on a fall of xfer
    a_r4_swap_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (sel != $past(sel)));

    // R4: the fill select holds otherwise
    a_r4_no_swap_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(sel));

    // R5: output holds while shifting is disabled
    a_r5_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        shift_n |=> $stable(rev_out));

    // R5: levels hold while shifting is disabled and no swap occurs
    a_r5_hold_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_n && !fall) |=> ($stable(lvl_a) && $stable(lvl_b)));

    // R6: popping an empty stack yields zero
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !shift_n && (drain_lvl == '0)) |=> (rev_out == '0));

    // R7: no stack exceeds its depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(lvl_a) <= DEPTH) && (int'(lvl_b) <= DEPTH)));

    // R8: a swap restarts the new filling stack
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (int'(fill_lvl) <= 1));
endmodule

bind pp_lifo_reverser pp_lifo_chk #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_n(shift_n),
    .xfer   (xfer),
    .rev_out(rev_out),
    .sel    (st_q.sel),
    .xfer_q (st_q.xfer),
    .lvl_a  (lvl[0]),
    .lvl_b  (lvl[1])
);

// File: tb/sim_pp_lifo_reverser.sv
`timescale 1ns/1ps
module sim_pp_lifo_reverser;
    localparam int DW    = 12;
    localparam int DEPTH = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] fwd_in = '0;
    logic          shift_n = 1'b1;
    logic          xfer = 1'b0;
    logic [DW-1:0] rev_out;

    int    checks = 0;
    int    bad = 0;
    string tag = "R1";

    int m_qa[$];
    int m_qb[$];
    bit m_sel = 1'b0;
    bit m_xprev = 1'b0;
    int m_exp = 0;

    always #2 clk = ~clk;

    pp_lifo_reverser #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd_in (fwd_in),
        .shift_n(shift_n),
        .xfer   (xfer),
        .rev_out(rev_out)
    );

    task automatic compare();
        checks++;
        if (rev_out !== DW'(m_exp)) begin
            bad++;
            $display("FAIL %s: rev_out=%h expected=%h", tag, rev_out, DW'(m_exp));
        end
    endtask

    task automatic model_step(input bit x, input bit sn, input int d);
        bit sw;
        sw = m_xprev && !x;
        m_xprev = x;
        if (sw) begin
            m_sel = ~m_sel;
            if (m_sel) m_qb.delete();
            else       m_qa.delete();
        end
        if (!sn) begin
            if (m_sel) begin
                m_exp = (m_qa.size() > 0) ? m_qa.pop_back() : 0;
                if (m_qb.size() < DEPTH) m_qb.push_back(d);
            end else begin
                m_exp = (m_qb.size() > 0) ? m_qb.pop_back() : 0;
                if (m_qa.size() < DEPTH) m_qa.push_back(d);
            end
        end
    endtask

    task automatic tick(input bit x, input bit sn, input int d);
        xfer    = x;
        shift_n = sn;
        fwd_in  = DW'(d);
        model_step(x, sn, d);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: output cleared by reset
        tag = "R1";
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2 R6: fill stack A, B is empty so pops give zero
        tag = "R2 R6";
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 16 + i);

        // R4: rising edge of xfer alone does not swap
        tag = "R4";
        tick(1'b1, 1'b1, 0);
        tick(1'b1, 1'b1, 0);
        // R3 R4: fall with shift, then xfer held low while draining
        tag = "R3 R4";
        for (int i = 0; i < 13; i++) tick(1'b0, 1'b0, 300 + i);

        // R5: stall with changing data
        tag = "R5";
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b1, 4000 + i);

        // R9 R8: swaps during continuous shifting, uneven segments
        tag = "R9 R8";
        for (int seg = 0; seg < 6; seg++) begin
            int len;
            len = (seg % 2 == 0) ? 8 : 5;
            tick(1'b1, 1'b0, 500 + seg * 16);
            for (int i = 1; i < len; i++) tick(1'b1, 1'b0, 500 + seg * 16 + i);
            tick(1'b0, 1'b0, 700 + seg);
        end

        // R7: overfill one stack, then drain it
        tag = "R7";
        tick(1'b1, 1'b1, 0);
        tick(1'b0, 1'b1, 0);
        for (int i = 0; i < DEPTH + 4; i++) tick(1'b0, 1'b0, 1000 + i);
        tick(1'b1, 1'b1, 0);
        for (int i = 0; i < DEPTH + 4; i++) tick(1'b0, 1'b0, 2000 + i);

        // R10: swap while stalled, then shift
        tag = "R10";
        tick(1'b1, 1'b1, 0);
        tick(1'b0, 1'b1, 0);
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 3000 + i);
        tick(1'b1, 1'b1, 0);
        tick(1'b0, 1'b1, 0);
        tick(1'b0, 1'b1, 0);
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 3100 + i);

        // R2: random mix of shifts, stalls and transfers
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            bit x;
            bit sn;
            x  = ($urandom_range(0, 5) == 0) ? ~m_xprev : m_xprev;
            sn = ($urandom_range(0, 3) == 0);
            tick(x, sn, int'($urandom_range(0, 4095)));
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule